// File: doc/BRIEF.md
# Copy Engine Interrupt Status Controller

This block holds the interrupt enable and status state for a bank of copy engines. Each engine has three registers reached over a register port: an enable register for copy-complete and watermark events, a separate enable register for the error event, and a status register. Events from the ring engines set status bits. Copy-complete and error events arrive as pulses. Watermark events are derived inside the block by comparing the occupancy count of each engine's source and destination rings against per-ring high and low thresholds.

Status bits are recorded whether or not they are enabled, and software clears them by writing ones. A per-engine pending vector shows which engines hold at least one enabled status bit. A shared interrupt handler reads that vector and services the flagged engines in ascending order. A single interrupt line is the OR of the pending vector. Reads are combinational from the selected engine and register.

Top module: `ce_irq_ctrl`

## Requirements
- R1: After reset, every status, event-enable and error-enable register reads 0, every watermark register has low threshold 0 and high threshold equal to the ring size (16 by default), and `irq` is 0.
- R2: A write with `reg_sel`=0 stores `reg_wdata[4:0]` into the event-enable register of engine `reg_eng`. It reads back with the upper bits 0, and the other engines are not affected.
- R3: A write with `reg_sel`=2 stores `reg_wdata[0]` as the error enable. An error pulse sets status bit 5 whatever that enable holds, and the engine becomes pending from it only when the enable is 1.
- R4: A write with `reg_sel`=1 clears each status bit whose `reg_wdata` bit is 1 and leaves every bit written 0 unchanged.
- R5: When an event and a clearing write hit the same status bit in the same cycle, the bit is set afterwards.
- R6: A status bit is recorded while disabled, and it does not make its engine pending. Enabling a bit whose status is already set makes the engine pending in the cycle after the write.
- R7: A source watermark register (`reg_sel`=3) and a destination watermark register (`reg_sel`=4) hold the low threshold in bits [7:0] and the high threshold in bits [15:8].
- R8: Status bit 1 (source ring) or bit 3 (destination ring) sets on the clock edge at which occupancy first exceeds the high threshold. It does not set again while occupancy stays above that threshold, even after it is cleared.
- R9: Status bit 2 (source ring) or bit 4 (destination ring) sets on the clock edge at which occupancy first falls below the low threshold. It does not set again while occupancy stays below that threshold.
- R10: Bit e of `eng_pend` is 1 exactly when engine e has a status bit set in bits [4:0] whose enable bit is set, or bit 5 set with the error enable set. `irq` is the OR of `eng_pend`. Status bit 0 is copy complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_eng | input | 2 | Engine index for the read or write |
| reg_sel | input | 3 | Register select: 0 event enable, 1 status, 2 error enable, 3 source watermark, 4 destination watermark |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| copy_done | input | 4 | Copy-complete pulse, one bit per engine |
| err_evt | input | 4 | Error pulse, one bit per engine |
| src_occ | input | 32 | Source ring occupancy, 8 bits per engine |
| dst_occ | input | 32 | Destination ring occupancy, 8 bits per engine |
| eng_pend | output | 4 | Per-engine pending summary |
| irq | output | 1 | OR of all pending bits |

## Verification
The assertions take event pulses and register writes as synchronous to the clock. They treat a clearing write as the only way a status bit can drop, and an event pulse in the prior cycle as the only way the copy-complete bit can rise. The stimulus changes inputs only at falling edges, holds occupancy steady between crossings, and gives each engine a non-crossing starting occupancy before thresholds are reprogrammed. That way the only watermark events are the ones the bench intends.

// File: rtl/ce_irq_pkg.sv
package ce_irq_pkg;
  typedef enum logic [2:0] {
    SEL_EVT_EN = 3'd0,
    SEL_STATUS = 3'd1,
    SEL_ERR_EN = 3'd2,
    SEL_SRC_WM = 3'd3,
    SEL_DST_WM = 3'd4
  } reg_sel_e;

  localparam int ST_W   = 6;
  localparam int EN_W   = 5;
  localparam int ST_CC  = 0;
  localparam int ST_SHI = 1;
  localparam int ST_SLO = 2;
  localparam int ST_DHI = 3;
  localparam int ST_DLO = 4;
  localparam int ST_ERR = 5;
endpackage

// File: rtl/ce_rst_sync.sv
module ce_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ce_wm_detect.sv
module ce_wm_detect #(
  parameter int OCC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] thr_hi,
  input  logic [OCC_W-1:0] thr_lo,
  output logic             hi_evt,
  output logic             lo_evt
);
  logic above_q, below_q;
  logic above_now, below_now;

  always_comb begin
    above_now = (occ > thr_hi);
    below_now = (occ < thr_lo);
    hi_evt    = above_now & ~above_q;
    lo_evt    = below_now & ~below_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      below_q <= 1'b0;
    end else begin
      above_q <= above_now;
      below_q <= below_now;
    end
  end
endmodule

// File: rtl/ce_eng_regs.sv
module ce_eng_regs
  import ce_irq_pkg::*;
#(
  parameter int OCC_W     = 8,
  parameter int RING_SIZE = 16,
  localparam int REG_W    = 2 * OCC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             cc_evt,
  input  logic             err_evt,
  input  logic [OCC_W-1:0] src_occ,
  input  logic [OCC_W-1:0] dst_occ,
  output logic [ST_W-1:0]  status,
  output logic [EN_W-1:0]  evt_en,
  output logic             err_en,
  output logic [REG_W-1:0] src_wm,
  output logic [REG_W-1:0] dst_wm,
  output logic             pend
);
  localparam logic [OCC_W-1:0] HI_RST = OCC_W'(RING_SIZE);

  logic [ST_W-1:0]  st_q, st_d, set_vec, clr_vec;
  logic [EN_W-1:0]  en_q, en_d;
  logic             een_q, een_d;
  logic [REG_W-1:0] swm_q, swm_d, dwm_q, dwm_d;
  logic             s_hi, s_lo, d_hi, d_lo;
  logic             upd;

  ce_wm_detect #(.OCC_W(OCC_W)) u_src_wm (
    .clk(clk), .rst_n(rst_n), .occ(src_occ),
    .thr_hi(swm_q[REG_W-1:OCC_W]), .thr_lo(swm_q[OCC_W-1:0]),
    .hi_evt(s_hi), .lo_evt(s_lo)
  );

  ce_wm_detect #(.OCC_W(OCC_W)) u_dst_wm (
    .clk(clk), .rst_n(rst_n), .occ(dst_occ),
    .thr_hi(dwm_q[REG_W-1:OCC_W]), .thr_lo(dwm_q[OCC_W-1:0]),
    .hi_evt(d_hi), .lo_evt(d_lo)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[ST_CC]  = cc_evt;
    set_vec[ST_SHI] = s_hi;
    set_vec[ST_SLO] = s_lo;
    set_vec[ST_DHI] = d_hi;
    set_vec[ST_DLO] = d_lo;
    set_vec[ST_ERR] = err_evt;
    clr_vec = (wr && sel == SEL_STATUS) ? wdata[ST_W-1:0] : '0;
    st_d    = (st_q & ~clr_vec) | set_vec;
    en_d    = (wr && sel == SEL_EVT_EN) ? wdata[EN_W-1:0] : en_q;
    een_d   = (wr && sel == SEL_ERR_EN) ? wdata[0] : een_q;
    swm_d   = (wr && sel == SEL_SRC_WM) ? wdata : swm_q;
    dwm_d   = (wr && sel == SEL_DST_WM) ? wdata : dwm_q;
    upd     = wr | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      en_q  <= '0;
      een_q <= 1'b0;
      swm_q <= {HI_RST, {OCC_W{1'b0}}};
      dwm_q <= {HI_RST, {OCC_W{1'b0}}};
    end else if (upd) begin
      st_q  <= st_d;
      en_q  <= en_d;
      een_q <= een_d;
      swm_q <= swm_d;
      dwm_q <= dwm_d;
    end
  end

  assign status = st_q;
  assign evt_en = en_q;
  assign err_en = een_q;
  assign src_wm = swm_q;
  assign dst_wm = dwm_q;
  assign pend   = (|(st_q[EN_W-1:0] & en_q)) | (st_q[ST_ERR] & een_q);
endmodule

// File: rtl/ce_irq_ctrl.sv
module ce_irq_ctrl
  import ce_irq_pkg::*;
#(
  parameter int N_ENG     = 4,
  parameter int OCC_W     = 8,
  parameter int RING_SIZE = 16,
  localparam int ENG_W    = (N_ENG > 1) ? $clog2(N_ENG) : 1,
  localparam int REG_W    = 2 * OCC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [ENG_W-1:0]       reg_eng,
  input  logic [2:0]             reg_sel,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  input  logic [N_ENG-1:0]       copy_done,
  input  logic [N_ENG-1:0]       err_evt,
  input  logic [N_ENG*OCC_W-1:0] src_occ,
  input  logic [N_ENG*OCC_W-1:0] dst_occ,
  output logic [N_ENG-1:0]       eng_pend,
  output logic                   irq
);
  logic                  rst_sync_n;
  logic [ST_W-1:0]       st_a   [N_ENG];
  logic [EN_W-1:0]       en_a   [N_ENG];
  logic                  een_a  [N_ENG];
  logic [REG_W-1:0]      swm_a  [N_ENG];
  logic [REG_W-1:0]      dwm_a  [N_ENG];
  logic [N_ENG*ST_W-1:0] st_flat;

  ce_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar e = 0; e < N_ENG; e++) begin : g_eng
    ce_eng_regs #(.OCC_W(OCC_W), .RING_SIZE(RING_SIZE)) u_regs (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr      (reg_wr && (reg_eng == ENG_W'(e))),
      .sel     (reg_sel),
      .wdata   (reg_wdata),
      .cc_evt  (copy_done[e]),
      .err_evt (err_evt[e]),
      .src_occ (src_occ[e*OCC_W +: OCC_W]),
      .dst_occ (dst_occ[e*OCC_W +: OCC_W]),
      .status  (st_a[e]),
      .evt_en  (en_a[e]),
      .err_en  (een_a[e]),
      .src_wm  (swm_a[e]),
      .dst_wm  (dwm_a[e]),
      .pend    (eng_pend[e])
    );
    assign st_flat[e*ST_W +: ST_W] = st_a[e];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_EVT_EN: reg_rdata[EN_W-1:0] = en_a[reg_eng];
      SEL_STATUS: reg_rdata[ST_W-1:0] = st_a[reg_eng];
      SEL_ERR_EN: reg_rdata[0]        = een_a[reg_eng];
      SEL_SRC_WM: reg_rdata           = swm_a[reg_eng];
      SEL_DST_WM: reg_rdata           = dwm_a[reg_eng];
      default:    reg_rdata           = '0;
    endcase
  end

  assign irq = |eng_pend;
endmodule

// File: rtl/ce_irq_ctrl_chk.sv
module ce_irq_ctrl_chk #(
  parameter int N_ENG = 4,
  parameter int ST_W  = 6,
  parameter int ENG_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [ENG_W-1:0]      reg_eng,
  input logic [2:0]            reg_sel,
  input logic                  wbit0,
  input logic [N_ENG-1:0]      copy_done,
  input logic [N_ENG-1:0]      err_evt,
  input logic [N_ENG*ST_W-1:0] st_flat,
  input logic [N_ENG-1:0]      eng_pend
);
  for (genvar e = 0; e < N_ENG; e++) begin : g_chk
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done[e] |=> st_flat[e*ST_W]);

    p_err_recorded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt[e] |=> st_flat[e*ST_W + ST_W - 1]);

    p_clear_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_flat[e*ST_W]) |->
        $past(reg_wr && reg_sel == 3'd1 && reg_eng == ENG_W'(e) && wbit0));

    p_rise_by_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_flat[e*ST_W]) |-> $past(copy_done[e]));

    p_pend_needs_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_pend[e] |-> (st_flat[e*ST_W +: ST_W] != '0));
  end
endmodule

bind ce_irq_ctrl ce_irq_ctrl_chk #(.N_ENG(N_ENG), .ST_W(ce_irq_pkg::ST_W), .ENG_W(ENG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_eng   (reg_eng),
  .reg_sel   (reg_sel),
  .wbit0     (reg_wdata[0]),
  .copy_done (copy_done),
  .err_evt   (err_evt),
  .st_flat   (st_flat),
  .eng_pend  (eng_pend)
);

// File: tb/sim_ce_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ce_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_eng;
  logic [2:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [3:0]  copy_done, err_evt;
  logic [31:0] src_occ, dst_occ;
  logic [3:0]  eng_pend;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ce_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_eng(reg_eng),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .copy_done(copy_done), .err_evt(err_evt), .src_occ(src_occ),
    .dst_occ(dst_occ), .eng_pend(eng_pend), .irq(irq)
  );

  // vector: op(0 write,1 read-check) | eng | sel | data | expected
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {2'd1, 2'd0, 3'd3, 16'h0000, 16'h1000},
    {2'd1, 2'd2, 3'd4, 16'h0000, 16'h1000},
    {2'd1, 2'd1, 3'd0, 16'h0000, 16'h0000},
    {2'd1, 2'd3, 3'd1, 16'h0000, 16'h0000},
    {2'd0, 2'd1, 3'd0, 16'hFFFF, 16'h0000},
    {2'd1, 2'd1, 3'd0, 16'h0000, 16'h001F},
    {2'd1, 2'd0, 3'd0, 16'h0000, 16'h0000},
    {2'd0, 2'd3, 3'd2, 16'hFFFF, 16'h0000},
    {2'd1, 2'd3, 3'd2, 16'h0000, 16'h0001},
    {2'd1, 2'd2, 3'd2, 16'h0000, 16'h0000},
    {2'd0, 2'd0, 3'd3, 16'h0A03, 16'h0000},
    {2'd1, 2'd0, 3'd3, 16'h0000, 16'h0A03},
    {2'd0, 2'd1, 3'd4, 16'h0802, 16'h0000},
    {2'd1, 2'd1, 3'd4, 16'h0000, 16'h0802}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] e, logic [2:0] s, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_eng = e; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] e, logic [2:0] s, output logic [15:0] d);
    @(negedge clk);
    reg_eng = e; reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(logic [3:0] cc, logic [3:0] er);
    @(negedge clk);
    copy_done = cc; err_evt = er;
    @(posedge clk); #1;
    copy_done = '0; err_evt = '0;
  endtask

  task automatic set_src0(logic [7:0] v);
    @(negedge clk);
    src_occ[7:0] = v;
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_eng = '0; reg_sel = '0; reg_wdata = '0;
    copy_done = '0; err_evt = '0; src_occ = '0; dst_occ = '0;
    src_occ[7:0]   = 8'd5;
    dst_occ[15:8]  = 8'd4;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq after reset", {15'd0, irq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][38:37] == 2'd0) wr(VEC[i][36:35], VEC[i][34:32], VEC[i][31:16]);
      else begin
        rd(VEC[i][36:35], VEC[i][34:32], d);
        check("table R1 R2 R3 R7", d, VEC[i][15:0]);
      end
    end

    // R6: recorded while disabled
    pulse(4'b0100, 4'b0000);
    rd(2'd2, 3'd1, d);  check("R6 status while disabled", d, 16'h0001);
    check("R6 no pend while disabled", {12'd0, eng_pend}, 16'h0000);
    wr(2'd2, 3'd0, 16'h0001);
    check("R6 pend after enable", {12'd0, eng_pend}, 16'h0004);
    check("R10 irq follows pend", {15'd0, irq}, 16'd1);
    // R4: write-one-to-clear
    wr(2'd2, 3'd1, 16'h0020);
    rd(2'd2, 3'd1, d);  check("R4 zero bit untouched", d, 16'h0001);
    wr(2'd2, 3'd1, 16'h0001);
    rd(2'd2, 3'd1, d);  check("R4 one clears", d, 16'h0000);
    check("R10 pend drops", {12'd0, eng_pend}, 16'h0000);
    // R5: collision
    @(negedge clk);
    copy_done = 4'b0100; reg_wr = 1'b1; reg_eng = 2'd2; reg_sel = 3'd1; reg_wdata = 16'h0001;
    @(posedge clk); #1;
    copy_done = '0; reg_wr = 1'b0;
    rd(2'd2, 3'd1, d);  check("R5 event beats clear", d, 16'h0001);
    wr(2'd2, 3'd1, 16'h003F);
    // R3: error enable
    pulse(4'b0000, 4'b1010);
    rd(2'd3, 3'd1, d);  check("R3 error status eng3", d, 16'h0020);
    rd(2'd1, 3'd1, d);  check("R3 error status eng1", d, 16'h0020);
    check("R3 pend only where enabled", {12'd0, eng_pend}, 16'h0008);
    wr(2'd3, 3'd1, 16'h003F);
    // R8 destination high on eng1 (enabled)
    @(negedge clk); dst_occ[15:8] = 8'd9; @(posedge clk); #1;
    rd(2'd1, 3'd1, d);  check("R8 dst high bit", d, 16'h0028);
    check("R10 pend eng1", {12'd0, eng_pend}, 16'h0002);
    wr(2'd1, 3'd1, 16'h003F);
    check("R10 irq low when clear", {15'd0, irq}, 16'd0);
    // R8/R9 source thresholds on eng0 (hi 10, lo 3)
    set_src0(8'd11);
    rd(2'd0, 3'd1, d);  check("R8 src high crossing", d, 16'h0002);
    wr(2'd0, 3'd1, 16'h003F);
    set_src0(8'd12);
    rd(2'd0, 3'd1, d);  check("R8 no repeat above", d, 16'h0000);
    set_src0(8'd10);
    set_src0(8'd11);
    rd(2'd0, 3'd1, d);  check("R8 second crossing", d, 16'h0002);
    wr(2'd0, 3'd1, 16'h003F);
    set_src0(8'd2);
    rd(2'd0, 3'd1, d);  check("R9 src low crossing", d, 16'h0004);
    wr(2'd0, 3'd1, 16'h0002);
    set_src0(8'd1);
    rd(2'd0, 3'd1, d);  check("R9 no repeat below", d, 16'h0004);
    check("R6 eng0 disabled", {12'd0, eng_pend}, 16'h0000);
    wr(2'd0, 3'd0, 16'h0004);
    check("R6 enable pending low mark", {12'd0, eng_pend}, 16'h0001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule